// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Sequencer

This block runs in the byte-clock domain of a serial display link transmitter and steers the clock lane between its low-power stop condition and continuous high-speed clocking. The data-lane logic raises a request when it wants a running clock. The sequencer then walks the lane through the low-power escape levels, the high-speed prepare and zero intervals, and a pre interval of running clock. Only after that does it grant the data lanes permission to send. When the request is withdrawn and the data lanes report that they are idle, the clock keeps running for a post interval. The lane is then driven to the trail level and returned to stop.

Every interval is a byte-clock count taken from an 8-bit field. A byte-clock period equals eight high-speed bit periods. One packed 32-bit timing word carries four of these counts. The pre interval has its own word, in which only the low byte is meaningful. The low-power interval has its own input. The block drives enable strobes and a two-bit low-power line level to the analog drivers, a clock-run flag to the serialiser, and stop and high-speed-active status for the lane.

Top module: `clk_lane_hs_seq`

## Requirements
- R1: While reset is applied and afterwards with `hs_req` low, the lane sits in stop: `lp_en`=1, `lp_line`=2'b11 (bit 1 is the positive wire), `stat_stop`=1, and `hs_en`, `clk_run`, `stat_hs_active` and `data_go` are all 0.
- R2: When `hs_req` is sampled high in stop, the next cycle starts LP-01 (`lp_line`=2'b01, `lp_en`=1) for the effective `lpx_len` cycles. LP-00 (`lp_line`=2'b00, `lp_en`=1) follows for the same count.
- R3: After LP-00, `hs_en`=1, `lp_en`=0 and `clk_run`=0 hold for the effective prepare count (`tim_word[31:24]`) plus the effective zero count (`tim_word[23:16]`).
- R4: The pre interval then runs with `hs_en`=1, `clk_run`=1, `stat_hs_active`=1 and `data_go`=0 for the effective count in `pre_word[7:0]`. `pre_word[31:8]` has no effect.
- R5: After the pre interval, `data_go`=1 with the clock running. This holds for as long as `hs_req` is high or `lanes_idle` is low.
- R6: In the first cycle of `data_go` with `hs_req` low and `lanes_idle` high, the next cycle begins the post interval. The post interval has the clock running, `stat_hs_active`=1 and `data_go`=0, and lasts for the effective `tim_word[15:8]`. The trail interval follows (`hs_en`=1, `clk_run`=0) for the effective `tim_word[7:0]`. The lane then returns to the stop state of R1.
- R7: A count of 0 in any field lasts exactly one cycle, like a count of 1.
- R8: `hs_req` raised during the post or trail interval is ignored. If it is low again on the return to stop, the lane stays in stop.
- R9: If the exit condition of R6 already holds when the pre interval expires, `data_go` is high for exactly one cycle before the post interval.
- R10: `stat_stop` is 1 only in stop. `stat_hs_active` is 1 only in the pre, released and post intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_req | input | 1 | Data-lane request for a running high-speed clock |
| lanes_idle | input | 1 | Data lanes have finished their high-speed bursts |
| tim_word | input | 32 | Packed counts: prepare [31:24], zero [23:16], post [15:8], trail [7:0] |
| pre_word | input | 32 | Pre-interval count in [7:0]; upper bits unused |
| lpx_len | input | 8 | Count for each of the LP-01 and LP-00 levels |
| hs_en | output | 1 | High-speed driver enable |
| lp_en | output | 1 | Low-power driver enable |
| lp_line | output | 2 | Low-power level, bit 1 positive wire, bit 0 negative wire |
| clk_run | output | 1 | Serialiser toggles the clock lane |
| stat_stop | output | 1 | Lane is in stop state |
| stat_hs_active | output | 1 | Lane is clocking in high speed |
| data_go | output | 1 | Data lanes may send |

## Verification
The delicate overlap is the end of the pre interval landing in the same cycle as an already-present exit condition. The sequencer must still grant `data_go` for one cycle before it starts the post interval. The bench provokes this by raising `hs_req` for a single cycle with `lanes_idle` high, so that the request is gone long before the clock starts. A scoreboard records every output run and expects a released run of exactly one cycle between the pre and post runs. A second overlap, a fresh request arriving while the exit is under way, is judged by the absence of any run beyond the expected list and by the lane still reporting stop several cycles after the exit.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

   typedef enum logic [3:0] {
      PH_STOP  = 4'd0,
      PH_LP01  = 4'd1,
      PH_LP00  = 4'd2,
      PH_PREP  = 4'd3,
      PH_ZERO  = 4'd4,
      PH_PRE   = 4'd5,
      PH_RUN   = 4'd6,
      PH_POST  = 4'd7,
      PH_TRAIL = 4'd8
   } phase_e;

   // positions of the effective lengths in the unpacked bundle
   localparam int LEN_N     = 6;
   localparam int LI_PREP   = 0;
   localparam int LI_ZERO   = 1;
   localparam int LI_POST   = 2;
   localparam int LI_TRAIL  = 3;
   localparam int LI_PRE    = 4;
   localparam int LI_LPX    = 5;

endpackage

// File: rtl/clk_lane_field_unpack.sv
module clk_lane_field_unpack
   import clk_lane_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int WORD_W = 32
)(
   input  logic [WORD_W-1:0]            tim_word,
   input  logic [WORD_W-1:0]            pre_word,
   input  logic [CNT_W-1:0]             lpx_len,
   output logic [LEN_N-1:0][CNT_W-1:0]  len_eff
);

   logic [LEN_N-1:0][CNT_W-1:0] len_raw;
   logic                        unused_pre_hi;

   if (WORD_W < 4*CNT_W) begin : g_bad_word
      $error("clk_lane_field_unpack: WORD_W too small for four fields");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("clk_lane_field_unpack: CNT_W must be at least 2");
   end

   always_comb begin
      len_raw[LI_PREP]  = tim_word[4*CNT_W-1:3*CNT_W];
      len_raw[LI_ZERO]  = tim_word[3*CNT_W-1:2*CNT_W];
      len_raw[LI_POST]  = tim_word[2*CNT_W-1:CNT_W];
      len_raw[LI_TRAIL] = tim_word[CNT_W-1:0];
      len_raw[LI_PRE]   = pre_word[CNT_W-1:0];
      len_raw[LI_LPX]   = lpx_len;
   end

   assign unused_pre_hi = ^pre_word[WORD_W-1:CNT_W];

   // a zero count is stretched to one cycle so no interval vanishes
   for (genvar i = 0; i < LEN_N; i++) begin : g_floor
      assign len_eff[i] = (len_raw[i] == '0) ? CNT_W'(1) : len_raw[i];
   end

endmodule

// File: rtl/clk_lane_phase_timer.sv
module clk_lane_phase_timer #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_len,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= CNT_W'(1);
      else if (load)         cnt_q <= load_len;
      else if (cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired = (cnt_q == CNT_W'(1));

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_len != '0)); // R7
   AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0); // R7
   AST_TMR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_len))); // R3

endmodule

// File: rtl/clk_lane_phase_fsm.sv
module clk_lane_phase_fsm
   import clk_lane_pkg::*;
#(
   parameter int CNT_W = 8
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hs_req,
   input  logic                        lanes_idle,
   input  logic                        expired,
   input  logic [LEN_N-1:0][CNT_W-1:0] len_eff,
   output phase_e                      phase,
   output logic                        load,
   output logic [CNT_W-1:0]            load_len
);

   phase_e phase_nxt;

   always_comb begin
      phase_nxt = phase;
      unique case (phase)
         PH_STOP:  if (hs_req)                 phase_nxt = PH_LP01;
         PH_LP01:  if (expired)                phase_nxt = PH_LP00;
         PH_LP00:  if (expired)                phase_nxt = PH_PREP;
         PH_PREP:  if (expired)                phase_nxt = PH_ZERO;
         PH_ZERO:  if (expired)                phase_nxt = PH_PRE;
         PH_PRE:   if (expired)                phase_nxt = PH_RUN;
         PH_RUN:   if (!hs_req && lanes_idle)  phase_nxt = PH_POST;
         PH_POST:  if (expired)                phase_nxt = PH_TRAIL;
         PH_TRAIL: if (expired)                phase_nxt = PH_STOP;
         default:                              phase_nxt = PH_STOP;
      endcase
   end

   always_comb begin
      unique case (phase_nxt)
         PH_LP01, PH_LP00: load_len = len_eff[LI_LPX];
         PH_PREP:          load_len = len_eff[LI_PREP];
         PH_ZERO:          load_len = len_eff[LI_ZERO];
         PH_PRE:           load_len = len_eff[LI_PRE];
         PH_POST:          load_len = len_eff[LI_POST];
         PH_TRAIL:         load_len = len_eff[LI_TRAIL];
         default:          load_len = CNT_W'(1);
      endcase
   end

   assign load = (phase_nxt != phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_STOP;
      else        phase <= phase_nxt;
   end

   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STOP && !hs_req) |=> (phase == PH_STOP)); // R1
   AST_ENTRY_LP01: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STOP && hs_req) |=> (phase == PH_LP01)); // R2
   AST_RUN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RUN && !lanes_idle) |=> (phase == PH_RUN)); // R5
   AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_POST || phase == PH_TRAIL) |=> (phase != PH_LP01)); // R8

endmodule

// File: rtl/clk_lane_hs_seq.sv
module clk_lane_hs_seq
   import clk_lane_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int WORD_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_req,
   input  logic              lanes_idle,
   input  logic [WORD_W-1:0] tim_word,
   input  logic [WORD_W-1:0] pre_word,
   input  logic [CNT_W-1:0]  lpx_len,
   output logic              hs_en,
   output logic              lp_en,
   output logic [1:0]        lp_line,
   output logic              clk_run,
   output logic              stat_stop,
   output logic              stat_hs_active,
   output logic              data_go
);

   logic [LEN_N-1:0][CNT_W-1:0] len_eff;
   logic                        tmr_load;
   logic [CNT_W-1:0]            tmr_len;
   logic                        tmr_expired;
   phase_e                      phase;

   clk_lane_field_unpack #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_unpack (
      .tim_word (tim_word),
      .pre_word (pre_word),
      .lpx_len  (lpx_len),
      .len_eff  (len_eff)
   );

   clk_lane_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .hs_req     (hs_req),
      .lanes_idle (lanes_idle),
      .expired    (tmr_expired),
      .len_eff    (len_eff),
      .phase      (phase),
      .load       (tmr_load),
      .load_len   (tmr_len)
   );

   clk_lane_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_len (tmr_len),
      .expired  (tmr_expired)
   );

   always_comb begin
      hs_en          = 1'b0;
      lp_en          = 1'b0;
      lp_line        = 2'b00;
      clk_run        = 1'b0;
      stat_stop      = 1'b0;
      stat_hs_active = 1'b0;
      data_go        = 1'b0;
      unique case (phase)
         PH_STOP: begin
            lp_en     = 1'b1;
            lp_line   = 2'b11;
            stat_stop = 1'b1;
         end
         PH_LP01: begin
            lp_en   = 1'b1;
            lp_line = 2'b01;
         end
         PH_LP00:                     lp_en = 1'b1;
         PH_PREP, PH_ZERO, PH_TRAIL:  hs_en = 1'b1;
         PH_PRE, PH_POST: begin
            hs_en          = 1'b1;
            clk_run        = 1'b1;
            stat_hs_active = 1'b1;
         end
         PH_RUN: begin
            hs_en          = 1'b1;
            clk_run        = 1'b1;
            stat_hs_active = 1'b1;
            data_go        = 1'b1;
         end
         default: begin
            lp_en   = 1'b1;
            lp_line = 2'b11;
         end
      endcase
   end

   AST_GO_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_go) |-> ($past(phase) == PH_PRE)); // R4
   AST_GO_DROP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_go) |-> (phase == PH_POST)); // R6
   AST_STOP_FROM_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_stop) |-> ($past(phase) == PH_TRAIL)); // R10

endmodule

// File: tb/clk_lane_hs_seq_test.sv
module clk_lane_hs_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hs_req = 1'b0;
   logic        lanes_idle = 1'b1;
   logic [31:0] tim_word = '0;
   logic [31:0] pre_word = '0;
   logic [7:0]  lpx_len = 8'd1;
   logic        hs_en, lp_en, clk_run, stat_stop, stat_hs_active, data_go;
   logic [1:0]  lp_line;

   int checks = 0;
   int failures = 0;
   bit mon_en = 1'b0;

   // signature {hs_en, lp_en, lp_line[1:0], clk_run, stat_stop, stat_hs_active, data_go}
   localparam logic [7:0] SG_STOP = 8'b0_1_11_0_1_0_0;
   localparam logic [7:0] SG_LP01 = 8'b0_1_01_0_0_0_0;
   localparam logic [7:0] SG_LP00 = 8'b0_1_00_0_0_0_0;
   localparam logic [7:0] SG_HS0  = 8'b1_0_00_0_0_0_0;
   localparam logic [7:0] SG_CLK  = 8'b1_0_00_1_0_1_0;
   localparam logic [7:0] SG_GO   = 8'b1_0_00_1_0_1_1;

   typedef struct {
      logic [7:0] sig;
      int         len;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   always #4 clk = ~clk;

   clk_lane_hs_seq uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .hs_req         (hs_req),
      .lanes_idle     (lanes_idle),
      .tim_word       (tim_word),
      .pre_word       (pre_word),
      .lpx_len        (lpx_len),
      .hs_en          (hs_en),
      .lp_en          (lp_en),
      .lp_line        (lp_line),
      .clk_run        (clk_run),
      .stat_stop      (stat_stop),
      .stat_hs_active (stat_hs_active),
      .data_go        (data_go)
   );

   function automatic logic [7:0] cur_sig();
      return {hs_en, lp_en, lp_line, clk_run, stat_stop, stat_hs_active, data_go};
   endfunction

   function automatic int eff(input logic [7:0] v);
      return (v == 8'd0) ? 1 : int'(v);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic push(input logic [7:0] s, input int l, input string t);
      exp_t e;
      e.sig = s;
      e.len = l;
      e.tag = t;
      exp_q.push_back(e);
   endtask

   // monitor: run-length compress the output signature and compare each run
   logic [7:0] run_sig;
   int         run_len = 0;
   bit         run_have = 1'b0;

   task automatic close_run(input logic [7:0] s, input int l);
      exp_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, "R8", "unexpected run sig", int'(s), 0);
      end else begin
         e = exp_q.pop_front();
         check(s == e.sig, e.tag, "run signature", int'(s), int'(e.sig));
         if (e.len != 0)
            check(l == e.len, e.tag, "run length", l, e.len);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (!run_have) begin
            run_sig  = cur_sig();
            run_len  = 1;
            run_have = 1'b1;
         end else if (cur_sig() == run_sig) begin
            run_len++;
         end else begin
            close_run(run_sig, run_len);
            run_sig = cur_sig();
            run_len = 1;
         end
      end
   end

   // mode 0 plain, 1 single-cycle request, 2 lanes busy after drop, 3 request during exit
   task automatic txn(input logic [31:0] tw, input logic [31:0] pw,
                      input logic [7:0] lx, input int mode, input string lbl);
      @(negedge clk);
      tim_word   = tw;
      pre_word   = pw;
      lpx_len    = lx;
      lanes_idle = (mode != 2);
      push(SG_STOP, 0, {"R1 ", lbl});
      push(SG_LP01, eff(lx), {"R2 ", lbl});
      push(SG_LP00, eff(lx), {"R2 ", lbl});
      push(SG_HS0, eff(tw[31:24]) + eff(tw[23:16]), {"R3 ", lbl});
      push(SG_CLK, eff(pw[7:0]), {"R4/R10 ", lbl});
      push(SG_GO, (mode == 1) ? 1 : 0, (mode == 1) ? {"R9 ", lbl} : {"R5 ", lbl});
      push(SG_CLK, eff(tw[15:8]), {"R6 ", lbl});
      push(SG_HS0, eff(tw[7:0]), {"R6 ", lbl});
      hs_req = 1'b1;
      if (mode == 1) begin
         @(negedge clk);
         hs_req = 1'b0;
      end else begin
         do @(negedge clk); while (!data_go);
         repeat (3) @(negedge clk);
         hs_req = 1'b0;
         if (mode == 2) begin
            repeat (20) @(negedge clk);
            check(data_go == 1'b1, "R5", "data_go while lanes busy", int'(data_go), 1);
            lanes_idle = 1'b1;
         end
         if (mode == 3) begin
            do @(negedge clk); while (!(clk_run && !data_go));
            hs_req = 1'b1;
            repeat (3) @(negedge clk);
            hs_req = 1'b0;
         end
      end
      do @(negedge clk); while (!stat_stop);
      repeat (6) @(negedge clk);
      check(stat_stop == 1'b1, (mode == 3) ? "R8" : "R6", "stop after exit",
            int'(stat_stop), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(cur_sig() == SG_STOP, "R1", "signature in reset", int'(cur_sig()), int'(SG_STOP));
      rst_n = 1'b1;
      mon_en = 1'b1;
      repeat (4) @(negedge clk);
      check(cur_sig() == SG_STOP, "R1", "signature after reset", int'(cur_sig()), int'(SG_STOP));
      check(stat_stop == 1'b1, "R10", "stop status idle", int'(stat_stop), 1);

      txn(32'h03_05_04_02, 32'h0000_0003, 8'd2, 0, "basic");
      txn(32'h00_00_00_00, 32'h0000_0000, 8'd0, 0, "R7 zeros");
      txn(32'h0A_02_07_01, 32'hABCD_EF06, 8'd4, 0, "R4 upper pre bits");
      txn(32'hFF_01_02_03, 32'h0000_0002, 8'd1, 0, "R3 max prepare");
      txn(32'h02_03_03_02, 32'h0000_0004, 8'd3, 2, "R5 busy lanes");
      txn(32'h02_02_02_02, 32'h0000_0005, 8'd2, 1, "R9 early drop");
      txn(32'h01_01_14_03, 32'h0000_0002, 8'd1, 3, "R8 late request");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R6", "runs left unseen", exp_q.size(), 0);
      check(run_sig == SG_STOP, "R6", "final run", int'(run_sig), int'(SG_STOP));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule